// File: doc/BRIEF.md
# Four-Phase Byte-Bus Command Endpoint

This block is the device-side end of an 8-bit parallel link that an external microcontroller drives. The host frames every transaction with a start level. It moves bytes one at a time with a request line. The block answers on a reply line, so both sides are fully interlocked and the host may run at any speed. Each transaction carries a six-byte command packet into the block and an eight-byte answer back out.

The inbound packet holds an opcode byte, a register address byte and a 32-bit write value sent lowest byte first. The block runs the opcode against a simple register port. Opcode 0x00 issues one write strobe and opcode 0x01 issues one read strobe. It then returns a data word and then a status word, each lowest byte first. Any other opcode touches nothing and reports status 1. An acknowledge output stays high from the start of the transaction until the last answer byte has completed its handshake. The host waits for that fall and then drops start.

The host's active-low reset and its start, direction and request lines are asynchronous to the block's clock. The reset is asserted at once and released through a synchroniser. The other three lines pass through a multi-flop synchroniser before the state machine uses them. The pad tristate is controlled with a separate output-enable.

Top module: `bytebus_slave`

## Requirements
- R1: While host_rst_n is low, and from the cycle it goes low, reply, ack, bus_oe, reg_wr_en and reg_rd_en are all 0.
- R2: From idle, ack rises on the third rising clock edge after host_start goes high (two synchroniser stages plus the state register).
- R3: For each inbound byte, reply rises after host_req is seen high, and falls after host_req is seen low.
- R4: Inbound framing is byte 0 opcode, byte 1 address, bytes 2..5 the write value, lowest byte first. Opcode 0x00 gives exactly one reg_wr_en pulse, with reg_addr equal to the address byte and reg_wdata equal to the assembled value. The answer is data 0 and status 0.
- R5: Opcode 0x01 gives exactly one reg_rd_en pulse at the address byte. The answer data word equals reg_rdata in the strobe cycle, and the status is 0.
- R6: Any other opcode gives no strobe, answer data 0 and status 0x00000001. The register contents are left unchanged.
- R7: The answer is eight bytes: the data word lowest byte first, then the status word lowest byte first. Each byte is valid on bus_out while reply is high.
- R8: bus_oe is 1 only while host_rw is 1 (1 means host reads, 0 means host writes) and the block is in the answer phase. It is 1 whenever reply is high in that phase.
- R9: ack falls after the host drops host_req on the eighth answer byte. After host_start goes low, a further transaction is accepted.
- R10: A reset pulse in the middle of a transaction returns the block to idle, and the next full transaction completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| host_rst_n | input | 1 | Asynchronous active-low reset from the host |
| host_start | input | 1 | Transaction framing level from the host |
| host_rw | input | 1 | Direction: 1 host reads, 0 host writes |
| host_req | input | 1 | Host request handshake |
| bus_in | input | 8 | Byte from the host side of the pad |
| bus_out | output | 8 | Byte driven toward the host |
| bus_oe | output | 1 | Pad output enable for bus_out |
| reply | output | 1 | Block reply handshake |
| ack | output | 1 | High for the duration of a transaction |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register read value, sampled in the read strobe cycle |

## Verification
Only the start-to-ack latency has a fixed due time. It is three rising edges after start, so the bench samples ack on the falling edges after the second and the third edge. Every other result waits on a level change of a handshake line. The bench host polls reply on falling edges with a bounded wait. It reads bus_out and bus_oe only while reply is high, and it checks the answer words and strobe counts after ack has fallen. The strobe counters and the enable-versus-direction monitor sample on clock edges, so they do not depend on the host's pace.

// File: rtl/bytebus_pkg.sv
package bytebus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_HI,
      ST_RX_LO,
      ST_EXEC,
      ST_TX_PUT,
      ST_TX_HI,
      ST_TX_LO,
      ST_DONE
   } bb_state_t;

   localparam logic [7:0] OP_WRITE = 8'h00;
   localparam logic [7:0] OP_READ  = 8'h01;

   localparam logic [7:0] STAT_OK      = 8'h00;
   localparam logic [7:0] STAT_BAD_OP  = 8'h01;

endpackage

// File: rtl/bytebus_sync.sv
module bytebus_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/bytebus_rx_asm.sv
module bytebus_rx_asm #(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BUS_W-1:0]  byte_in,
   output logic [BUS_W-1:0]  pkt_op,
   output logic [ADDR_W-1:0] pkt_addr,
   output logic [DATA_W-1:0] pkt_data
);

   localparam int IN_BYTES = 2 + DATA_W / BUS_W;
   localparam int SR_W     = IN_BYTES * BUS_W;

   logic [SR_W-1:0] sr;

   // lowest byte arrives first, so new bytes enter at the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (clr)  sr <= '0;
      else if (load) sr <= {byte_in, sr[SR_W-1:BUS_W]};
   end

   assign pkt_op   = sr[BUS_W-1:0];
   assign pkt_addr = sr[BUS_W +: ADDR_W];
   assign pkt_data = sr[2*BUS_W +: DATA_W];

   generate
      if (ADDR_W < BUS_W) begin : g_addr_pad
         logic unused_addr_bits;
         assign unused_addr_bits = ^sr[BUS_W+ADDR_W +: BUS_W-ADDR_W];
      end
   endgenerate

endmodule

// File: rtl/bytebus_tx_sel.sv
module bytebus_tx_sel #(
   parameter int BUS_W  = 8,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0] word_lo,
   input  logic [DATA_W-1:0] word_hi,
   input  logic [IDX_W-1:0]  idx,
   output logic [BUS_W-1:0]  byte_out
);

   localparam int OUT_BYTES = 2 * DATA_W / BUS_W;

   logic [2*DATA_W-1:0] pkt;
   logic [BUS_W-1:0]    lanes [OUT_BYTES];

   assign pkt = {word_hi, word_lo};

   for (genvar g = 0; g < OUT_BYTES; g++) begin : g_lane
      assign lanes[g] = pkt[g*BUS_W +: BUS_W];
   end

   always_comb begin
      byte_out = '0;
      for (int i = 0; i < OUT_BYTES; i++)
         if (idx == IDX_W'(i)) byte_out = lanes[i];
   end

endmodule

// File: rtl/bytebus_slave.sv
module bytebus_slave
   import bytebus_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2
) (
   input  logic              clk,
   input  logic              host_rst_n,
   input  logic              host_start,
   input  logic              host_rw,
   input  logic              host_req,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              reply,
   output logic              ack,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int WORD_BYTES = DATA_W / BUS_W;
   localparam int IN_BYTES   = 2 + WORD_BYTES;
   localparam int OUT_BYTES  = 2 * WORD_BYTES;
   localparam int MAX_BYTES  = (IN_BYTES > OUT_BYTES) ? IN_BYTES : OUT_BYTES;
   localparam int CNT_W      = $clog2(MAX_BYTES + 1);
   localparam int IDX_W      = $clog2(OUT_BYTES);

   generate
      if (BUS_W < 8)              begin : g_chk_bus  $error("BUS_W must hold an opcode byte"); end
      if (DATA_W % BUS_W != 0)    begin : g_chk_div  $error("DATA_W must be a multiple of BUS_W"); end
      if (WORD_BYTES < 1)         begin : g_chk_word $error("DATA_W must be at least BUS_W"); end
      if (ADDR_W > BUS_W)         begin : g_chk_addr $error("ADDR_W must fit in one bus byte"); end
      if (SYNC_STAGES < 2)        begin : g_chk_sync $error("SYNC_STAGES must be at least 2"); end
      if (RST_STAGES < 2)         begin : g_chk_rst  $error("RST_STAGES must be at least 2"); end
   endgenerate

   // reset: asserted at once, released on the clock
   logic [RST_STAGES-1:0] rst_pipe;
   logic                  rst_n_s;

   always_ff @(posedge clk or negedge host_rst_n) begin
      if (!host_rst_n) rst_pipe <= '0;
      else             rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
   end
   assign rst_n_s = rst_pipe[RST_STAGES-1];

   // control line synchronisers
   logic start_s, rw_s, req_s;

   bytebus_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n_s),
      .d     ({host_start, host_rw, host_req}),
      .q     ({start_s, rw_s, req_s})
   );

   bb_state_t           state;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W-1:0]   ans_data, ans_stat;
   logic [BUS_W-1:0]    pkt_op;
   logic [ADDR_W-1:0]   pkt_addr;
   logic [DATA_W-1:0]   pkt_data;
   logic                rx_clr, rx_load;
   logic                op_wr, op_rd;

   assign rx_clr  = (state == ST_IDLE) && start_s;
   assign rx_load = (state == ST_RX_HI) && req_s && !rw_s;

   bytebus_rx_asm #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .clr      (rx_clr),
      .load     (rx_load),
      .byte_in  (bus_in),
      .pkt_op   (pkt_op),
      .pkt_addr (pkt_addr),
      .pkt_data (pkt_data)
   );

   bytebus_tx_sel #(.BUS_W(BUS_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_tx (
      .word_lo  (ans_data),
      .word_hi  (ans_stat),
      .idx      (cnt[IDX_W-1:0]),
      .byte_out (bus_out)
   );

   assign op_wr     = (pkt_op == BUS_W'(OP_WRITE));
   assign op_rd     = (pkt_op == BUS_W'(OP_READ));
   assign reg_wr_en = (state == ST_EXEC) && op_wr;
   assign reg_rd_en = (state == ST_EXEC) && op_rd;
   assign reg_addr  = pkt_addr;
   assign reg_wdata = pkt_data;

   assign bus_oe = rw_s && ((state == ST_TX_PUT) || (state == ST_TX_HI) || (state == ST_TX_LO));

   always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         reply    <= 1'b0;
         ack      <= 1'b0;
         ans_data <= '0;
         ans_stat <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_s) begin
                  ack   <= 1'b1;
                  cnt   <= '0;
                  state <= ST_RX_HI;
               end
            end
            ST_RX_HI: begin
               if (req_s && !rw_s) begin
                  reply <= 1'b1;
                  state <= ST_RX_LO;
               end
            end
            ST_RX_LO: begin
               if (!req_s) begin
                  reply <= 1'b0;
                  if (cnt == CNT_W'(IN_BYTES - 1)) begin
                     cnt   <= '0;
                     state <= ST_EXEC;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     state <= ST_RX_HI;
                  end
               end
            end
            ST_EXEC: begin
               if (op_wr) begin
                  ans_data <= '0;
                  ans_stat <= DATA_W'(STAT_OK);
               end else if (op_rd) begin
                  ans_data <= reg_rdata;
                  ans_stat <= DATA_W'(STAT_OK);
               end else begin
                  ans_data <= '0;
                  ans_stat <= DATA_W'(STAT_BAD_OP);
               end
               state <= ST_TX_PUT;
            end
            ST_TX_PUT: begin
               if (rw_s && !req_s) begin
                  reply <= 1'b1;
                  state <= ST_TX_HI;
               end
            end
            ST_TX_HI: begin
               if (req_s) begin
                  reply <= 1'b0;
                  state <= ST_TX_LO;
               end
            end
            ST_TX_LO: begin
               if (!req_s) begin
                  if (cnt == CNT_W'(OUT_BYTES - 1)) begin
                     cnt   <= '0;
                     ack   <= 1'b0;
                     state <= ST_DONE;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     state <= ST_TX_PUT;
                  end
               end
            end
            ST_DONE: begin
               if (!start_s) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: ack only rises when leaving idle
   assert_ack_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(ack) |-> ($past(state) == ST_IDLE));

   // R3: an inbound reply rise follows a seen request
   assert_rx_reply_rise_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
      ($rose(reply) && (state == ST_RX_LO)) |-> $past(req_s));

   // R4 / R5: strobes are exclusive single-cycle pulses
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
      !(reg_wr_en && reg_rd_en));
   assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
      (reg_wr_en || reg_rd_en) |=> !(reg_wr_en || reg_rd_en));

   // R7: byte counter stays within the packet length
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
      cnt < CNT_W'(MAX_BYTES));

   // R8: the pad is driven only inside a transaction
   assert_oe_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
      bus_oe |-> ack);

   // R9: ack falls only after the last answer handshake
   assert_ack_fall_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
      $fell(ack) |-> (state == ST_DONE) && !reply);

endmodule

// File: tb/test_bytebus_slave.sv
module test_bytebus_slave;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;
   localparam int TMO = 200;

   // {opcode, address, value}
   localparam logic [47:0] VEC [NVEC] = '{
      {8'h00, 8'h01, 32'hA5A5_1234},
      {8'h01, 8'h01, 32'h0000_0000},
      {8'h00, 8'h02, 32'hDEAD_BEEF},
      {8'h01, 8'h02, 32'h1111_1111},
      {8'h00, 8'h03, 32'h8000_0001},
      {8'h01, 8'h03, 32'h0000_0000},
      {8'h07, 8'h01, 32'hFFFF_FFFF},
      {8'h01, 8'h01, 32'h0000_0000},
      {8'hFF, 8'h00, 32'h0BAD_0BAD}
   };

   logic        clk = 1'b0;
   logic        host_rst_n = 1'b0;
   logic        host_start = 1'b0;
   logic        host_rw = 1'b0;
   logic        host_req = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic [7:0]  bus_out;
   logic        bus_oe, reply, ack, reg_wr_en, reg_rd_en;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;

   int checks = 0;
   int fails = 0;
   int wr_pulses = 0;
   int rd_pulses = 0;
   int oe_viol = 0;
   logic [7:0]  last_wr_addr;
   logic [31:0] last_wr_data;
   logic [31:0] regs [4];
   logic [31:0] exp_regs [4];
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bytebus_slave i_bytebus_slave (
      .clk(clk), .host_rst_n(host_rst_n), .host_start(host_start),
      .host_rw(host_rw), .host_req(host_req), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .reply(reply), .ack(ack),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // bench register file
   assign reg_rdata = regs[reg_addr[1:0]];

   always @(posedge clk) begin
      if (reg_wr_en) begin
         regs[reg_addr[1:0]] <= reg_wdata;
         wr_pulses++;
         last_wr_addr <= reg_addr;
         last_wr_data <= reg_wdata;
      end
      if (reg_rd_en) rd_pulses++;
   end

   always @(negedge clk) if (bus_oe && !host_rw) oe_viol++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_reply(input logic lvl, input string tag);
      int n = 0;
      while (reply !== lvl && n < TMO) begin
         @(negedge clk);
         n++;
      end
      if (reply !== lvl) check(tag, {31'b0, reply}, {31'b0, lvl});
   endtask

   task automatic wait_ack(input logic lvl, input string tag);
      int n = 0;
      while (ack !== lvl && n < TMO) begin
         @(negedge clk);
         n++;
      end
      if (ack !== lvl) check(tag, {31'b0, ack}, {31'b0, lvl});
   endtask

   task automatic put_byte(input logic [7:0] b);
      host_rw = 1'b0;
      bus_in  = b;
      @(negedge clk);
      host_req = 1'b1;
      wait_reply(1'b1, "R3 reply rise");
      host_req = 1'b0;
      wait_reply(1'b0, "R3 reply fall");
   endtask

   task automatic get_byte(output logic [7:0] b);
      host_rw = 1'b1;
      wait_reply(1'b1, "R7 answer reply");
      if (!bus_oe) check("R8 oe during answer", {31'b0, bus_oe}, 32'd1);
      b = bus_out;
      host_req = 1'b1;
      wait_reply(1'b0, "R7 answer release");
      host_req = 1'b0;
   endtask

   task automatic transact(input logic [7:0] op, input logic [7:0] addr, input logic [31:0] val,
                           output logic [31:0] d, output logic [31:0] s);
      logic [7:0] b;
      host_start = 1'b1;
      wait_ack(1'b1, "R2 ack rise");
      put_byte(op);
      put_byte(addr);
      for (int i = 0; i < 4; i++) put_byte(val[8*i +: 8]);
      for (int i = 0; i < 4; i++) begin get_byte(b); d[8*i +: 8] = b; end
      for (int i = 0; i < 4; i++) begin get_byte(b); s[8*i +: 8] = b; end
      wait_ack(1'b0, "R9 ack fall");
      host_start = 1'b0;
      host_rw = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset();
      host_rst_n = 1'b0;
      host_start = 1'b0;
      host_req = 1'b0;
      host_rw = 1'b0;
      @(negedge clk);
      check("R1 reply in reset", {31'b0, reply}, 32'd0);
      check("R1 ack in reset", {31'b0, ack}, 32'd0);
      check("R1 oe/strobes in reset", {29'b0, bus_oe, reg_wr_en, reg_rd_en}, 32'd0);
      host_rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, s, ed, es;
      int w0, r0;
      for (int i = 0; i < 4; i++) begin regs[i] = 32'h0; exp_regs[i] = 32'h0; end
      repeat (3) @(negedge clk);
      // R1: immediate reset state
      do_reset();

      // R2: ack latency of three rising edges
      host_start = 1'b1;
      repeat (2) @(negedge clk);
      check("R2 ack before third edge", {31'b0, ack}, 32'd0);
      @(negedge clk);
      check("R2 ack at third edge", {31'b0, ack}, 32'd1);
      // R10: abort after two bytes
      put_byte(8'h00);
      put_byte(8'h02);
      do_reset();
      check("R10 ack after abort", {31'b0, ack}, 32'd0);
      check("R10 reply after abort", {31'b0, reply}, 32'd0);

      // table walk: R4 R5 R6 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0]  op, ad;
         logic [31:0] val;
         {op, ad, val} = VEC[v];
         w0 = wr_pulses;
         r0 = rd_pulses;
         transact(op, ad, val, d, s);
         if (op == 8'h00) begin
            ed = 32'h0; es = 32'h0;
            exp_regs[ad[1:0]] = val;
            check("R4 write strobe count", wr_pulses - w0, 1);
            check("R4 write address", {24'b0, last_wr_addr}, {24'b0, ad});
            check("R4 write value", last_wr_data, val);
            check("R4 no read strobe", rd_pulses - r0, 0);
         end else if (op == 8'h01) begin
            ed = exp_regs[ad[1:0]]; es = 32'h0;
            check("R5 read strobe count", rd_pulses - r0, 1);
            check("R5 no write strobe", wr_pulses - w0, 0);
         end else begin
            ed = 32'h0; es = 32'h1;
            check("R6 no strobes", (wr_pulses - w0) + (rd_pulses - r0), 0);
         end
         check("R7 answer data word", d, ed);
         check("R7 answer status word", s, es);
      end

      // R10: full transaction after the abort still matches
      transact(8'h01, 8'h02, 32'h0, d, s);
      check("R10 read after abort", d, exp_regs[2]);
      check("R6 registers untouched by bad op", regs[1], 32'hA5A5_1234);
      check("R8 oe only while host reads", oe_viol, 0);
      check("R9 idle after start low", {31'b0, ack}, 32'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule